// File: doc/BRIEF.md
# Inbound DMA Address Window Translator

This block sits on the inbound path of a PCIe-style root port. It takes the 64-bit bus address of each request and maps it to a host target address. The address is first sorted into one of five fixed windows. The first is a 64-bit direct window, where attribute bits ride in the top of the address. The second is a 32-bit direct window, which takes its upper bits from a per-port register. The other three are page-table windows, each with its own page size and its own slice of a table.

The output carries the target address, the window code, an MSI flag, a barrier (ordered access) flag and a fault flag. A request lands on one of two downstream ports, chosen from its bus number. Translation entries, the two direct-map registers and the small-window page size are loaded through a one-cycle register-write port.

Requests and responses each use a valid/ready handshake. Every translation takes a fixed two cycles.

Top module: `inbound_xlat`

## Requirements
- R1: An address with bit 63 set is window code 1. The target is the address with bits 63..61 cleared. The MSI flag is address bit 61 and the barrier flag is address bit 62.
- R2: Addresses 0x8000_0000..0xFFFF_FFFF are window code 2. The target is the direct-map register of the requesting port, with its low 30 bits cleared, ORed with address bits 29..0. The barrier flag is address bit 30 and the MSI flag is 0.
- R3: Addresses 0..0x7FFF_FFFF are window code 3. They use the shared table. The index is the address shifted right by the page shift, which is 18 after reset (256 KB pages) and can be set to any value from 12 to 30.
- R4: Addresses 0x40_0000_0000..0x7F_FFFF_FFFF are window code 4. They use a separate table with 64 MB pages, indexed by (address - 0x40_0000_0000) >> 26. The barrier flag is always 0 in this window.
- R5: Addresses 0x80_0000_0000..0xFF_FFFF_FFFF are window code 5. They use 16 GB pages in the shared table at index port*32 + ((address - 0x80_0000_0000) >> 34).
- R6: A table entry carries valid at bit 63 and MSI-enable at bit 62. Bits 61..0 hold the target, truncated down to the page size. The result is that page base plus the address offset within the page. The MSI flag is entry bit 62, and the barrier flag is 0 for every table window.
- R7: A request whose bus number is below `port1_bus` belongs to port 0. Any other request, including one with a bus number equal to `port1_bus`, belongs to port 1.
- R8: A fault is raised for any of three causes: an address in no window (window code 0), an index at or beyond the table depth, or an entry whose valid bit is clear. On a fault, the target, MSI flag and barrier flag are all 0.
- R9: A request is accepted on the edge where `req_valid` and `req_ready` are both high. Its response is valid after the following edge. The response is held unchanged while `rsp_ready` is low. A write to the tables or registers is seen by requests accepted on later edges, but not by a request accepted on the same edge as the write.
- R10: Reset clears every table entry and both direct-map registers to zero and sets the page shift to 18. After reset, `rsp_valid` is 0 and `req_ready` is 1.
- R11: Write port target codes for `wr_sel` are:
  - 0: shared-table entry `wr_idx`.
  - 1: 64 MB table entry `wr_idx`.
  - 2: direct-map register of port `wr_idx[0]`.
  - 3: page shift, taken from `wr_data[5:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port1_bus | input | 8 | First bus number owned by port 1 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 64 | Inbound bus address |
| req_bus | input | 8 | Requester bus number |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target code (R11) |
| wr_idx | input | WR_IW (7) | Entry or port index |
| wr_data | input | 64 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response can be taken |
| rsp_addr | output | 64 | Host target address |
| rsp_msi | output | 1 | MSI write flag |
| rsp_barrier | output | 1 | Barrier flag |
| rsp_fault | output | 1 | Translation fault |
| rsp_win | output | 3 | Window code |

## Verification
A request driven before edge k is accepted at k. The bench samples at the falling edge after k and requires `rsp_valid` to still be low. At the next falling edge, after edge k+1, it compares every response field with values worked out from the range arithmetic in the requirements. Writes that land on the acceptance edge are checked against the table contents from before that write; the same request is then repeated to see the new contents. With `rsp_ready` held low, the response is sampled over several falling edges and must not move, and it must disappear one edge after `rsp_ready` returns high.

// File: rtl/inbound_xlat_pkg.sv
package inbound_xlat_pkg;

  typedef enum logic [2:0] {
    WIN_NONE = 3'd0,
    WIN_D64  = 3'd1,
    WIN_D32  = 3'd2,
    WIN_M32  = 3'd3,
    WIN_M40  = 3'd4,
    WIN_M40S = 3'd5
  } win_e;

  localparam logic [1:0] SEL_SHR  = 2'd0;
  localparam logic [1:0] SEL_M40  = 2'd1;
  localparam logic [1:0] SEL_DMAP = 2'd2;
  localparam logic [1:0] SEL_PGSH = 2'd3;

  localparam logic [5:0] M40_SHIFT  = 6'd26;
  localparam logic [5:0] M40S_SHIFT = 6'd34;

  // Window selection from fixed ranges.
  function automatic win_e win_of(input logic [63:0] a);
    win_e w;
    if (a[63])                 w = WIN_D64;
    else if (a[62:40] != '0)   w = WIN_NONE;
    else if (a[39])            w = WIN_M40S;
    else if (a[38])            w = WIN_M40;
    else if (a[37:32] != '0)   w = WIN_NONE;
    else if (a[31])            w = WIN_D32;
    else                       w = WIN_M32;
    return w;
  endfunction

  function automatic logic [63:0] low_mask(input logic [5:0] sh);
    return (64'd1 << sh) - 64'd1;
  endfunction

  // Page base from entry, offset from address.
  function automatic logic [63:0] splice(input logic [63:0] entry,
                                         input logic [63:0] addr,
                                         input logic [5:0]  sh);
    logic [63:0] m;
    m = low_mask(sh);
    return ({2'b00, entry[61:0]} & ~m) | (addr & m);
  endfunction

endpackage

// File: rtl/inbound_xlat_decode.sv
module inbound_xlat_decode
  import inbound_xlat_pkg::*;
#(
  parameter int SHR_DEPTH = 128,
  parameter int M40_DEPTH = 16,
  parameter int SHR_IW    = 7,
  parameter int M40_IW    = 4
) (
  input  logic [63:0]       addr,
  input  logic [7:0]        bus,
  input  logic [7:0]        port1_bus,
  input  logic [5:0]        m32_shift,
  output win_e              win,
  output logic              port,
  output logic [SHR_IW-1:0] shr_idx,
  output logic [M40_IW-1:0] m40_idx,
  output logic              in_range,
  output logic [5:0]        page_shift
);

  logic [63:0] m32_raw;
  logic [63:0] m40_raw;
  logic [63:0] m40s_raw;

  always_comb begin
    win      = win_of(addr);
    port     = (bus >= port1_bus);
    m32_raw  = {33'd0, addr[30:0]} >> m32_shift;
    m40_raw  = {52'd0, addr[37:26]};
    m40s_raw = {58'd0, port, addr[38:34]};
    shr_idx    = '0;
    m40_idx    = '0;
    in_range   = 1'b0;
    page_shift = '0;
    case (win)
      WIN_M32: begin
        shr_idx    = m32_raw[SHR_IW-1:0];
        in_range   = (m32_raw < 64'(SHR_DEPTH));
        page_shift = m32_shift;
      end
      WIN_M40: begin
        m40_idx    = m40_raw[M40_IW-1:0];
        in_range   = (m40_raw < 64'(M40_DEPTH));
        page_shift = M40_SHIFT;
      end
      WIN_M40S: begin
        shr_idx    = m40s_raw[SHR_IW-1:0];
        in_range   = (m40s_raw < 64'(SHR_DEPTH));
        page_shift = M40S_SHIFT;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/inbound_xlat_tables.sv
module inbound_xlat_tables
  import inbound_xlat_pkg::*;
#(
  parameter int SHR_DEPTH = 128,
  parameter int M40_DEPTH = 16,
  parameter int SHR_IW    = 7,
  parameter int M40_IW    = 4,
  parameter int WR_IW     = 7,
  parameter int DEF_SHIFT = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WR_IW-1:0]  wr_idx,
  input  logic [63:0]       wr_data,
  input  logic [SHR_IW-1:0] shr_idx,
  input  logic [M40_IW-1:0] m40_idx,
  input  logic              port,
  output logic [63:0]       shr_entry,
  output logic [63:0]       m40_entry,
  output logic [63:0]       dmap,
  output logic [5:0]        m32_shift
);

  logic [63:0] shr_mem [SHR_DEPTH];
  logic [63:0] m40_mem [M40_DEPTH];
  logic [63:0] dmap_q  [2];
  logic [5:0]  shift_q;

  wire wr_shr  = wr_en && (wr_sel == SEL_SHR);
  wire wr_m40  = wr_en && (wr_sel == SEL_M40);
  wire wr_dmap = wr_en && (wr_sel == SEL_DMAP);
  wire wr_pgsh = wr_en && (wr_sel == SEL_PGSH);

  for (genvar g = 0; g < SHR_DEPTH; g++) begin : g_shr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 shr_mem[g] <= '0;
      else if (wr_shr && wr_idx == WR_IW'(g))     shr_mem[g] <= wr_data;
    end
  end

  for (genvar g = 0; g < M40_DEPTH; g++) begin : g_m40
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 m40_mem[g] <= '0;
      else if (wr_m40 && wr_idx == WR_IW'(g))     m40_mem[g] <= wr_data;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_dmap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 dmap_q[g] <= '0;
      else if (wr_dmap && wr_idx[0] == 1'(g))     dmap_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shift_q <= 6'(DEF_SHIFT);
    else if (wr_pgsh) shift_q <= wr_data[5:0];
  end

  assign shr_entry = shr_mem[shr_idx];
  assign m40_entry = m40_mem[m40_idx];
  assign dmap      = dmap_q[port];
  assign m32_shift = shift_q;

endmodule

// File: rtl/inbound_xlat_compose.sv
module inbound_xlat_compose
  import inbound_xlat_pkg::*;
(
  input  win_e        win,
  input  logic [63:0] addr,
  input  logic [63:0] entry,
  input  logic [63:0] dmap,
  input  logic        in_range,
  input  logic [5:0]  page_shift,
  output logic [63:0] tgt,
  output logic        msi,
  output logic        barrier,
  output logic        fault
);

  always_comb begin
    tgt     = '0;
    msi     = 1'b0;
    barrier = 1'b0;
    fault   = 1'b0;
    case (win)
      WIN_D64: begin
        tgt     = {3'b000, addr[60:0]};
        msi     = addr[61];
        barrier = addr[62];
      end
      WIN_D32: begin
        tgt     = {dmap[63:30], addr[29:0]};
        barrier = addr[30];
      end
      WIN_M32, WIN_M40, WIN_M40S: begin
        fault = !in_range || !entry[63];
        tgt   = splice(entry, addr, page_shift);
        msi   = entry[62];
      end
      default: fault = 1'b1;
    endcase
    if (fault) begin
      tgt     = '0;
      msi     = 1'b0;
      barrier = 1'b0;
    end
  end

endmodule

// File: rtl/inbound_xlat.sv
module inbound_xlat
  import inbound_xlat_pkg::*;
#(
  parameter int SHR_DEPTH      = 128,
  parameter int M40_DEPTH      = 16,
  parameter int DEF_PAGE_SHIFT = 18,
  localparam int SHR_IW = $clog2(SHR_DEPTH),
  localparam int M40_IW = $clog2(M40_DEPTH),
  localparam int WR_IW  = (SHR_IW > M40_IW) ? SHR_IW : M40_IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       port1_bus,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [63:0]      req_addr,
  input  logic [7:0]       req_bus,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [WR_IW-1:0] wr_idx,
  input  logic [63:0]      wr_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [63:0]      rsp_addr,
  output logic             rsp_msi,
  output logic             rsp_barrier,
  output logic             rsp_fault,
  output logic [2:0]       rsp_win
);

  // acceptance-side decode and table read
  win_e              d_win;
  logic              d_port;
  logic [SHR_IW-1:0] d_shr_idx;
  logic [M40_IW-1:0] d_m40_idx;
  logic              d_inr;
  logic [5:0]        d_shift;
  logic [63:0]       t_shr, t_m40, t_dmap;
  logic [5:0]        t_m32_shift;

  inbound_xlat_decode #(
    .SHR_DEPTH(SHR_DEPTH), .M40_DEPTH(M40_DEPTH),
    .SHR_IW(SHR_IW), .M40_IW(M40_IW)
  ) u_decode (
    .addr(req_addr), .bus(req_bus), .port1_bus(port1_bus),
    .m32_shift(t_m32_shift), .win(d_win), .port(d_port),
    .shr_idx(d_shr_idx), .m40_idx(d_m40_idx), .in_range(d_inr),
    .page_shift(d_shift)
  );

  inbound_xlat_tables #(
    .SHR_DEPTH(SHR_DEPTH), .M40_DEPTH(M40_DEPTH), .SHR_IW(SHR_IW),
    .M40_IW(M40_IW), .WR_IW(WR_IW), .DEF_SHIFT(DEF_PAGE_SHIFT)
  ) u_tables (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_idx(wr_idx), .wr_data(wr_data), .shr_idx(d_shr_idx),
    .m40_idx(d_m40_idx), .port(d_port), .shr_entry(t_shr),
    .m40_entry(t_m40), .dmap(t_dmap), .m32_shift(t_m32_shift)
  );

  // stage 1 registers
  logic        s1_valid_q;
  win_e        s1_win;
  logic [63:0] s1_addr, s1_entry, s1_dmap;
  logic        s1_inr;
  logic [5:0]  s1_shift;

  // stage 2 (response) registers
  logic        rsp_valid_q;
  logic [63:0] rsp_addr_q;
  logic        rsp_msi_q, rsp_bar_q, rsp_fault_q;
  win_e        rsp_win_q;

  // named handshake events
  wire s2_free  = !rsp_valid_q || rsp_ready;
  wire s1_adv   = s1_valid_q && s2_free;
  wire s1_open  = !s1_valid_q || s2_free;
  wire req_fire = req_valid && s1_open;

  logic [63:0] c_tgt;
  logic        c_msi, c_bar, c_fault;

  inbound_xlat_compose u_compose (
    .win(s1_win), .addr(s1_addr), .entry(s1_entry), .dmap(s1_dmap),
    .in_range(s1_inr), .page_shift(s1_shift), .tgt(c_tgt),
    .msi(c_msi), .barrier(c_bar), .fault(c_fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_win     <= WIN_NONE;
      s1_addr    <= '0;
      s1_entry   <= '0;
      s1_dmap    <= '0;
      s1_inr     <= 1'b0;
      s1_shift   <= '0;
    end else if (s1_open) begin
      s1_valid_q <= req_valid;
      if (req_fire) begin
        s1_win   <= d_win;
        s1_addr  <= req_addr;
        s1_entry <= (d_win == WIN_M40) ? t_m40 : t_shr;
        s1_dmap  <= t_dmap;
        s1_inr   <= d_inr;
        s1_shift <= d_shift;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_addr_q  <= '0;
      rsp_msi_q   <= 1'b0;
      rsp_bar_q   <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_win_q   <= WIN_NONE;
    end else if (s2_free) begin
      rsp_valid_q <= s1_valid_q;
      if (s1_adv) begin
        rsp_addr_q  <= c_tgt;
        rsp_msi_q   <= c_msi;
        rsp_bar_q   <= c_bar;
        rsp_fault_q <= c_fault;
        rsp_win_q   <= s1_win;
      end
    end
  end

  assign req_ready   = s1_open;
  assign rsp_valid   = rsp_valid_q;
  assign rsp_addr    = rsp_addr_q;
  assign rsp_msi     = rsp_msi_q;
  assign rsp_barrier = rsp_bar_q;
  assign rsp_fault   = rsp_fault_q;
  assign rsp_win     = rsp_win_q;

endmodule

// File: rtl/inbound_xlat_checker.sv
module inbound_xlat_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [63:0] rsp_addr,
  input logic        rsp_msi,
  input logic        rsp_barrier,
  input logic        rsp_fault,
  input logic [2:0]  rsp_win,
  input logic        s1_valid,
  input logic        s1_adv
);

  AST_D64_STRIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_win == 3'd1 |-> rsp_addr[63:61] == 3'b000 && !rsp_fault); // R1

  AST_D32_NO_MSI: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_win == 3'd2 |-> !rsp_msi && !rsp_fault); // R2

  AST_M40_NO_BARRIER: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_win == 3'd4 |-> !rsp_barrier); // R4

  AST_TABLE_NO_BARRIER: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_win == 3'd3 || rsp_win == 3'd5) |-> !rsp_barrier); // R6

  AST_NONE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_win == 3'd0 |-> rsp_fault); // R8

  AST_FAULT_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_addr == 64'd0 && !rsp_msi && !rsp_barrier); // R8

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)
                               && $stable(rsp_win) && $stable(rsp_msi)); // R9

  AST_STAGE_TO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    s1_adv |=> rsp_valid); // R9

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |-> req_ready); // R9

endmodule

bind inbound_xlat inbound_xlat_checker chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_msi(rsp_msi),
  .rsp_barrier(rsp_barrier), .rsp_fault(rsp_fault), .rsp_win(rsp_win),
  .s1_valid(s1_valid_q), .s1_adv(s1_adv)
);

// File: tb/inbound_xlat_tb_top.sv
module inbound_xlat_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  port1_bus = 8'h10;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic [7:0]  req_bus = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [6:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_addr;
  logic        rsp_msi, rsp_barrier, rsp_fault;
  logic [2:0]  rsp_win;

  always #2.5 clk = ~clk;

  inbound_xlat dut_i (
    .clk(clk), .rst_n(rst_n), .port1_bus(port1_bus), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_bus(req_bus),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_msi(rsp_msi), .rsp_barrier(rsp_barrier), .rsp_fault(rsp_fault),
    .rsp_win(rsp_win)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side model of programmed state
  logic [63:0] shr_m [128];
  logic [63:0] m40_m [16];
  logic [63:0] dmap_m [2];
  int          shift_m = 18;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void expect_of(input logic [63:0] a, input logic [7:0] bus,
                                    output logic [63:0] ea, output logic [5:0] eflags);
    logic [63:0] page, idx, ent, base;
    int p, w, depth;
    bit tab, msi, bar, flt, m40t;
    p = (bus >= port1_bus) ? 1 : 0;
    tab = 0; m40t = 0; msi = 0; bar = 0; flt = 0; ea = 0;
    page = 1; idx = 0; depth = 128;
    if (a >= 64'h8000_0000_0000_0000) begin
      w = 1; ea = a % (64'd1 << 61); msi = a[61]; bar = a[62];
    end else if (a >= 64'h80_0000_0000 && a <= 64'hFF_FFFF_FFFF) begin
      w = 5; tab = 1; page = 64'd1 << 34; base = 64'h80_0000_0000;
      idx = 64'(p * 32) + (a - base) / page;
    end else if (a >= 64'h40_0000_0000 && a <= 64'h7F_FFFF_FFFF) begin
      w = 4; tab = 1; m40t = 1; depth = 16; page = 64'd1 << 26;
      base = 64'h40_0000_0000; idx = (a - base) / page;
    end else if (a >= 64'h8000_0000 && a <= 64'hFFFF_FFFF) begin
      w = 2; ea = (dmap_m[p] / (64'd1 << 30)) * (64'd1 << 30) + a % (64'd1 << 30);
      bar = ((a / (64'd1 << 30)) % 2) == 1;
    end else if (a <= 64'h7FFF_FFFF) begin
      w = 3; tab = 1; page = 64'd1 << shift_m; idx = a / page;
    end else begin
      w = 0; flt = 1;
    end
    if (tab) begin
      if (idx >= 64'(depth)) flt = 1;
      else begin
        ent = m40t ? m40_m[idx] : shr_m[idx];
        if (!ent[63]) flt = 1;
        else begin
          ea = ((ent % (64'd1 << 62)) / page) * page + a % page;
          msi = ent[62];
        end
      end
    end
    if (flt) begin ea = 0; msi = 0; bar = 0; end
    eflags = {3'(w), flt, msi, bar};
  endfunction

  task automatic model_write(input logic [1:0] s, input int i, input logic [63:0] d);
    case (s)
      2'd0: shr_m[i] = d;
      2'd1: m40_m[i] = d;
      2'd2: dmap_m[i % 2] = d;
      default: shift_m = int'(d[5:0]);
    endcase
  endtask

  task automatic tb_write(input logic [1:0] s, input int i, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_idx = 7'(i); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    model_write(s, i, d);
  endtask

  // One request; optional write on the acceptance edge. Response due after 2nd edge.
  task automatic xact(input logic [63:0] a, input logic [7:0] bus, input string req,
                      input bit do_wr, input logic [1:0] s, input int i,
                      input logic [63:0] d);
    logic [63:0] ea;
    logic [5:0]  ef;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_bus = bus;
    if (do_wr) begin wr_en = 1; wr_sel = s; wr_idx = 7'(i); wr_data = d; end
    expect_of(a, bus, ea, ef);
    @(negedge clk);
    req_valid = 0; wr_en = 0;
    if (do_wr) model_write(s, i, d);
    chk(!rsp_valid, "R9", "early rsp_valid", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    chk(rsp_valid, "R9", "rsp_valid due", 64'(rsp_valid), 64'd1);
    chk(rsp_addr == ea, req, "target", rsp_addr, ea);
    chk({rsp_win, rsp_fault, rsp_msi, rsp_barrier} == ef, req,
        "win/fault/msi/barrier", 64'({rsp_win, rsp_fault, rsp_msi, rsp_barrier}), 64'(ef));
  endtask

  task automatic xq(input logic [63:0] a, input logic [7:0] bus, input string req);
    xact(a, bus, req, 0, 2'd0, 0, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    for (int i = 0; i < 128; i++) shr_m[i] = '0;
    for (int i = 0; i < 16; i++) m40_m[i] = '0;
    dmap_m[0] = '0; dmap_m[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(!rsp_valid, "R10", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk(req_ready, "R10", "req_ready after reset", 64'(req_ready), 64'd1);
    xq(64'h0000_1234, 8'h00, "R10");
    xq(64'h8123_4567, 8'h00, "R10");
    xq(64'h40_0000_0100, 8'h00, "R10");

    // program tables (R11)
    for (int i = 0; i < 128; i++)
      if (i != 70)
        tb_write(2'd0, i, {1'b1, i[0], 62'((64'(i + 3) << 34) | (64'(i) * 64'h1357))});
    for (int i = 0; i < 16; i++)
      if (i != 5)
        tb_write(2'd1, i, {1'b1, i[1], 62'((64'(i + 9) << 26) | 64'h3FF)});
    tb_write(2'd2, 0, 64'hABCD_0000_1234_5678);
    tb_write(2'd2, 1, 64'h0000_0012_C000_0000);

    // R3/R6/R8 small window, 256 KB pages
    for (int i = 0; i < 130; i++)
      xq((64'(i) << 18) + 64'((i * 7919) % 262144), 8'h00, "R3");
    xq(64'h7FFF_FFFF, 8'h00, "R8");
    // R3 page shift changed to 16
    tb_write(2'd3, 0, 64'd16);
    for (int i = 0; i < 130; i++)
      xq((64'(i) << 16) + 64'((i * 977) % 65536), 8'h20, "R3");
    tb_write(2'd3, 0, 64'd18);

    // R4 64 MB window
    for (int i = 0; i < 17; i++)
      xq(64'h40_0000_0000 + (64'(i) << 26) + 64'((i * 123457) % 67108864) + 64'h4000_0000 * 64'(i % 2 == 0 ? 0 : 0),
         8'h00, "R4");
    xq(64'h40_0000_0000 + 64'h4000_0000 + 64'h123, 8'h00, "R4");
    xq(64'h7F_FFFF_FFFF, 8'h00, "R8");

    // R5/R7 16 GB window, both ports, boundary bus numbers
    for (int p = 0; p < 2; p++)
      for (int j = 0; j < 32; j++)
        xq(64'h80_0000_0000 + (64'(j) << 34) + 64'(j * 1000003),
           (p == 1) ? 8'(port1_bus + 8'(j % 3)) : 8'(port1_bus - 8'd1 - 8'(j % 3)), "R5");

    // R2/R7 32-bit direct window
    foreach (held[k]) ;
    xq(64'h8000_0000, 8'h00, "R2");
    xq(64'hC000_0001, 8'h0F, "R2");
    xq(64'hFFFF_FFFF, 8'h10, "R7");
    xq(64'hBFFF_FFFF, 8'hFF, "R7");
    xq(64'hD555_AAAA, 8'h10, "R2");

    // R1 64-bit direct window
    xq(64'h8000_0000_0000_0000, 8'h00, "R1");
    xq(64'hE000_0000_DEAD_BEEF, 8'h00, "R1");
    xq(64'hA123_4567_89AB_CDEF, 8'h00, "R1");
    xq(64'hC000_0000_0000_1000, 8'h00, "R1");
    xq(64'hFFFF_FFFF_FFFF_FFFF, 8'h00, "R1");

    // R8 holes between windows
    xq(64'h1_0000_0000, 8'h00, "R8");
    xq(64'h3F_FFFF_FFFF, 8'h00, "R8");
    xq(64'h100_0000_0000, 8'h00, "R8");
    xq(64'h7FFF_FFFF_FFFF_FFFF, 8'h00, "R8");

    // R9 write on acceptance edge is not seen; next request sees it
    xact(64'd5 << 18, 8'h00, "R9", 1, 2'd0, 5, 64'hC000_0000_7700_0000);
    xq(64'd5 << 18, 8'h00, "R9");
    xact(64'hC000_0042, 8'h00, "R9", 1, 2'd2, 0, 64'h0000_0003_4000_0000);
    xq(64'hC000_0042, 8'h00, "R9");
    xact(64'd70 << 18, 8'h00, "R9", 1, 2'd0, 70, 64'h8000_0000_0000_0000);
    xq(64'd70 << 18, 8'h00, "R9");

    // R9 backpressure: held response
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_addr = 64'hE000_0000_0000_0ABC; req_bus = 0;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    held = rsp_addr;
    chk(rsp_valid && held == 64'h0000_0000_0000_0ABC, "R9", "stall first", held, 64'h0ABC);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_addr == held, "R9", "stall hold", rsp_addr, held);
    end
    rsp_ready = 1;
    @(negedge clk);
    chk(!rsp_valid, "R9", "drain after release", 64'(rsp_valid), 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule